// File: doc/BRIEF.md
# Message-Driven SPI Master

This block is an SPI master that runs one complete message at a time. Software first loads transmit bytes into an internal transmit buffer. It then programs a message word that holds a byte count and a transfer kind. Last, it writes a command word that names the target device and starts the engine. The engine selects that device, shifts every byte out MSB first, and stores the bytes it receives into a receive buffer. When the message ends it releases the select and raises a done flag, which can also drive an interrupt line.

The serial clock comes from the system clock through a power-of-two divider chosen by a 3-bit rate code. Clock polarity and phase can be set in all four combinations. A half-duplex read can start with a number of written command bytes before its read phase. A receive-tail register reports how many bytes were captured. A write longer than the buffer is split by software into several messages, each of which refills the buffer.

The register space is split by the top address bit. When it is clear, the low three bits pick a control register. When it is set, the low bits index the buffers: writes go to the transmit buffer and reads come from the receive buffer.

Top module: `spi_msg_master`

## Requirements
- R1: After reset every select output is high, sclk is low, irq is low, and the done flag (reg 3), busy (reg 5) and receive tail (reg 6) all read 0.
- R2: Reg 0 bits [2:0] hold a rate code c. Each sclk half period lasts 2^c system cycles for c = 0..6. Code 7 runs at the same rate as code 6, the slowest.
- R3: Reg 0 bit 4 (polarity) sets the idle level of sclk. With reg 0 bit 5 (phase) at 0, MISO is sampled on the leading edge of each bit. With phase at 1, it is sampled on the trailing edge. Bytes travel MSB first.
- R4: Reg 1 bits [7:0] hold the byte count and bits [9:8] the transfer kind: 0 full duplex, 1 write only, 2 read only, 3 treated as full duplex. Every write byte sends transmit buffer entry k for message byte k. Every byte that is not a write byte sends 0x00. A message of n bytes gives exactly 16n sclk edges.
- R5: Command bits [15:8] hold a prepend count P. In a read-only message the first P bytes are sent from the transmit buffer and are not captured. If P is equal to or greater than the count, every byte is written.
- R6: Each captured byte is stored at the next receive buffer index, starting at 0. Reg 6 then equals the number of captured bytes: the count for full duplex, count−P for read only, and 0 for write only.
- R7: Writing reg 2 with bit 0 set and a device id in bits [7:4] starts a message. Only select line id goes low, it stays low for the whole message, and there is one select pulse per message. An id of NUM_CS or higher starts nothing.
- R8: Reg 5 bit 0 reads 1 while a message runs. A start command written while busy is ignored.
- R9: The done flag (reg 3 bit 0) is set when a message ends. irq is the done flag gated by the mask (reg 4 bit 0). Writing reg 3 with bit 0 set clears the flag.
- R10: A count above DEPTH is cut to DEPTH bytes. A count of 0 sets the done flag at once, with no select pulse and no clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register or buffer write strobe |
| regAddr | input | ADDR_W | Write address; top bit selects the transmit buffer |
| regWrData | input | 16 | Write data |
| regRdAddr | input | ADDR_W | Read address; top bit selects the receive buffer |
| regRdData | output | 16 | Combinational read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| csN | output | NUM_CS | Active-low device selects |
| irq | output | 1 | Masked command-done interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a start command that lands while a message is already running. The bench reaches it by starting a slow message and then polling busy through the status register. Once busy reads 1, it writes a second command aimed at another device. It then checks that only one select pulse was seen and that the edge count and device still match the first message. The second situation arises with phase 1. There the last bit of each byte is sampled on the same system edge that closes the byte. Random messages in all four clock modes, checked by a bench model of the device, show whether that final bit reaches the receive buffer.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;

  typedef enum logic [1:0] {
    MSG_DUPLEX = 2'd0,
    MSG_WRONLY = 2'd1,
    MSG_RDONLY = 2'd2,
    MSG_SPARE  = 2'd3
  } msgKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // reload transmit shifter
    logic loadData;  // reload from buffer (else zero)
    logic shift;     // advance transmit shifter
    logic sample;    // shift miso into receive shifter
    logic store;     // commit received byte
    logic clear;     // restart receive tail
  } dpCtl_t;

endpackage

// File: rtl/spi_msg_ctrl.sv
module spi_msg_ctrl
  import spi_msg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regIdx,
  input  logic [15:0]       wrData,
  input  logic [2:0]        rdIdx,
  output logic [15:0]       regRdData,
  input  logic [CNT_W-1:0]  rxTail,
  output dpCtl_t            dpCtl,
  output logic [IDX_W-1:0]  loadIdx,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic              busy,
  output logic              doneStat,
  output logic              cpol,
  output logic              irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL} state_t;

  state_t             state;
  logic [2:0]         rateCode;
  logic               cpha, maskBit, sclkI;
  logic [7:0]         msgCount, prepL;
  msgKind_t           msgKind, kindL;
  logic [CNT_W-1:0]   totalL, byteIdx, cntEff;
  logic [NUM_CS-1:0]  selL;
  logic [6:0]         divCnt, halfLen;
  logic [3:0]         edgeCnt;
  logic [2:0]         effCode;
  logic               tick, cmdWr, startOk, startRun, startEmpty;
  logic               xferTick, leadEdge, lastEdge, lastByte;
  logic [3:0]         devId;
  logic               unusedBits;

  assign unusedBits = ^wrData[3:1];

  function automatic logic isWrite(msgKind_t k, logic [CNT_W-1:0] i, logic [7:0] p);
    return (k != MSG_RDONLY) || (8'(i) < p);
  endfunction

  function automatic logic isRead(msgKind_t k, logic [CNT_W-1:0] i, logic [7:0] p);
    return (k != MSG_WRONLY) && !((k == MSG_RDONLY) && (8'(i) < p));
  endfunction

  assign effCode    = (rateCode == 3'd7) ? 3'd6 : rateCode;
  assign halfLen    = 7'd1 << effCode;
  assign tick       = (divCnt == halfLen - 7'd1);
  assign devId      = wrData[7:4];
  assign cmdWr      = regWe && (regIdx == 3'd2) && wrData[0];
  assign startOk    = cmdWr && (state == ST_IDLE) && (int'(devId) < NUM_CS);
  assign cntEff     = (msgCount > 8'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(msgCount);
  assign startRun   = startOk && (cntEff != '0);
  assign startEmpty = startOk && (cntEff == '0);
  assign xferTick   = (state == ST_XFER) && tick;
  assign leadEdge   = ~edgeCnt[0];
  assign lastEdge   = (edgeCnt == 4'd15);
  assign lastByte   = (byteIdx == totalL - 1'b1);

  always_comb begin
    dpCtl   = '0;
    loadIdx = '0;
    if (startRun) begin
      dpCtl.load     = 1'b1;
      dpCtl.clear    = 1'b1;
      dpCtl.loadData = isWrite(msgKind, '0, wrData[15:8]);
    end else if (xferTick) begin
      dpCtl.store = lastEdge && isRead(kindL, byteIdx, prepL);
      if (cpha) begin
        dpCtl.sample = !leadEdge;
        dpCtl.shift  = leadEdge && (edgeCnt != 4'd0);
        if (leadEdge && (edgeCnt == 4'd0)) begin
          dpCtl.load     = 1'b1;
          dpCtl.loadData = isWrite(kindL, byteIdx, prepL);
          loadIdx        = byteIdx[IDX_W-1:0];
        end
      end else begin
        dpCtl.sample = leadEdge;
        dpCtl.shift  = !leadEdge && !lastEdge;
        if (lastEdge && !lastByte) begin
          dpCtl.load     = 1'b1;
          dpCtl.loadData = isWrite(kindL, byteIdx + 1'b1, prepL);
          loadIdx        = IDX_W'(byteIdx + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rateCode <= '0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      msgCount <= '0;
      msgKind  <= MSG_DUPLEX;
      doneStat <= 1'b0;
      maskBit  <= 1'b0;
      kindL    <= MSG_DUPLEX;
      prepL    <= '0;
      totalL   <= '0;
      selL     <= '0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      byteIdx  <= '0;
      sclkI    <= 1'b0;
    end else begin
      if (regWe) begin
        case (regIdx)
          3'd0: begin
            rateCode <= wrData[2:0];
            cpol     <= wrData[4];
            cpha     <= wrData[5];
          end
          3'd1: begin
            msgCount <= wrData[7:0];
            msgKind  <= msgKind_t'(wrData[9:8]);
          end
          3'd3: if (wrData[0]) doneStat <= 1'b0;
          3'd4: maskBit <= wrData[0];
          default: ;
        endcase
      end
      if (state != ST_IDLE) divCnt <= tick ? '0 : divCnt + 7'd1;
      case (state)
        ST_IDLE: begin
          if (startRun) begin
            state   <= ST_LEAD;
            kindL   <= msgKind;
            prepL   <= wrData[15:8];
            totalL  <= cntEff;
            selL    <= NUM_CS'(1) << devId;
            divCnt  <= '0;
            edgeCnt <= '0;
            byteIdx <= '0;
            sclkI   <= 1'b0;
          end else if (startEmpty) begin
            doneStat <= 1'b1;
          end
        end
        ST_LEAD: if (tick) state <= ST_XFER;
        ST_XFER: begin
          if (tick) begin
            sclkI   <= ~sclkI;
            edgeCnt <= edgeCnt + 4'd1;
            if (lastEdge) begin
              if (lastByte) state <= ST_TAIL;
              else byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state    <= ST_IDLE;
            doneStat <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = busy ? ~selL : '1;
  assign sclk = sclkI ^ cpol;
  assign irq  = doneStat & maskBit;

  always_comb begin
    case (rdIdx)
      3'd0:    regRdData = {10'd0, cpha, cpol, 1'b0, rateCode};
      3'd1:    regRdData = {6'd0, msgKind, msgCount};
      3'd3:    regRdData = {15'd0, doneStat};
      3'd4:    regRdData = {15'd0, maskBit};
      3'd5:    regRdData = {15'd0, busy};
      3'd6:    regRdData = 16'(rxTail);
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_msg_dp.sv
module spi_msg_dp
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic             bufWe,
  input  logic [IDX_W-1:0] bufIdx,
  input  logic [7:0]       wrByte,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdByte,
  input  logic             miso,
  output logic             mosi,
  output logic [CNT_W-1:0] rxTail
);

  logic [7:0] txMem [DEPTH];
  logic [7:0] rxMem [DEPTH];
  logic [7:0] txSh, rxSh, rxNext;

  assign rxNext = dpCtl.sample ? {rxSh[6:0], miso} : rxSh;

  always_ff @(posedge clk) begin
    if (bufWe && (int'(bufIdx) < DEPTH)) txMem[bufIdx] <= wrByte;
    if (dpCtl.store) rxMem[rxTail[IDX_W-1:0]] <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rxTail <= '0;
    end else begin
      if (dpCtl.load) txSh <= dpCtl.loadData ? txMem[loadIdx] : 8'h00;
      else if (dpCtl.shift) txSh <= {txSh[6:0], 1'b0};
      rxSh <= rxNext;
      if (dpCtl.clear) rxTail <= '0;
      else if (dpCtl.store) rxTail <= rxTail + 1'b1;
    end
  end

  assign mosi   = txSh[7];
  assign rdByte = rxMem[rdIdx];

endmodule

// File: rtl/spi_msg_master.sv
module spi_msg_master
  import spi_msg_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_CS   = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int ADDR_W  = ((IDX_W > 3) ? IDX_W : 3) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [15:0]       regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);

  dpCtl_t           dpCtl;
  logic [IDX_W-1:0] loadIdx;
  logic [CNT_W-1:0] rxTail;
  logic [15:0]      ctrlRd;
  logic [7:0]       bufRd;
  logic             busy, doneStat, cfgCpol;
  logic             wrBuf, rdBuf;

  assign wrBuf = regAddr[ADDR_W-1];
  assign rdBuf = regRdAddr[ADDR_W-1];

  spi_msg_ctrl #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWr && !wrBuf), .regIdx(regAddr[2:0]), .wrData(regWrData),
    .rdIdx(regRdAddr[2:0]), .regRdData(ctrlRd), .rxTail(rxTail),
    .dpCtl(dpCtl), .loadIdx(loadIdx), .sclk(sclk), .csN(csN),
    .busy(busy), .doneStat(doneStat), .cpol(cfgCpol), .irq(irq)
  );

  spi_msg_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .loadIdx(loadIdx),
    .bufWe(regWr && wrBuf), .bufIdx(regAddr[IDX_W-1:0]), .wrByte(regWrData[7:0]),
    .rdIdx(regRdAddr[IDX_W-1:0]), .rdByte(bufRd),
    .miso(miso), .mosi(mosi), .rxTail(rxTail)
  );

  assign regRdData = rdBuf ? {8'd0, bufRd} : ctrlRd;

endmodule

// File: rtl/spi_msg_master_chk.sv
module spi_msg_master_chk #(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              clrBit,
  input logic [NUM_CS-1:0] csN,
  input logic              sclk,
  input logic              busy,
  input logic              doneStat,
  input logic              cpol,
  input logic [CNT_W-1:0]  rxTail
);

  // R7: never more than one device selected
  p_one_select_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R3: clock stays at rest while no device is selected
  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(&csN) && (&csN) && $stable(cpol)) |-> $stable(sclk));

  // R9: the end of a message leaves the done flag set
  p_end_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneStat);

  // R9: a clear write while idle drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWr && (regAddr == ADDR_W'(3)) && clrBit && !busy) |-> !doneStat);

  // R6: receive tail never exceeds the buffer depth
  p_tail_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxTail <= CNT_W'(DEPTH));

endmodule

bind spi_msg_master spi_msg_master_chk #(
  .DEPTH(DEPTH), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .clrBit(regWrData[0]),
  .csN(csN), .sclk(sclk), .busy(busy), .doneStat(doneStat), .cpol(cfgCpol),
  .rxTail(rxTail)
);

// File: tb/spi_msg_master_tb.sv
module spi_msg_master_tb;

  localparam int DEPTH  = 8;
  localparam int NUM_CS = 4;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0, regRdAddr = '0;
  logic [15:0]       regWrData = '0;
  logic [15:0]       regRdData;
  logic              sclk, mosi, miso, irq;
  logic [NUM_CS-1:0] csN;

  spi_msg_master #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // ---------------- device model ----------------
  int          eCnt = 0, csFalls = 0;
  logic [3:0]  lastSel = '1;
  logic [7:0]  slvRx [16];
  logic        slvCpha = 1'b0;
  logic [7:0]  respSeed = 8'h00;
  time         t1 = 0, t2 = 0;
  logic        csIdle;
  logic [7:0]  txMem [DEPTH];

  assign csIdle = &csN;

  function automatic logic [7:0] respByte(logic [7:0] s, int k);
    return s ^ 8'(k * 29 + 90);
  endfunction

  function automatic logic slaveBit(int e, logic ph, logic [7:0] s);
    int pos;
    logic [7:0] b;
    pos = ph ? ((e == 0) ? 0 : e - 1) : e;
    b = respByte(s, pos / 16);
    return b[7 - ((pos % 16) / 2)];
  endfunction

  assign miso = slaveBit(eCnt, slvCpha, respSeed);

  always @(negedge csIdle) begin
    eCnt = 0;
    csFalls = csFalls + 1;
    lastSel = csN;
  end

  always @(sclk) begin
    if (csIdle === 1'b0) begin
      eCnt = eCnt + 1;
      if (eCnt == 1) t1 = $time;
      if (eCnt == 2) t2 = $time;
      if (slvCpha ? (eCnt % 2 == 0) : (eCnt % 2 == 1)) begin
        int b;
        b = (eCnt - 1) / 16;
        if (b < 16) slvRx[b] = {slvRx[b][6:0], mosi};
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = ADDR_W'(a); regWrData = 16'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    @(negedge clk);
    regRdAddr = ADDR_W'(a);
    #1 v = regRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(5, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic bit expWr(int typ, int k, int p);
    return (typ != 2) || (k < p);
  endfunction

  function automatic bit expRd(int typ, int k, int p);
    return (typ != 1) && !((typ == 2) && (k < p));
  endfunction

  task automatic runMsg(int typ, int cnt, int prep, int dev, int code, int pol, int pha, int mask);
    int eff, half, tail, j, falls0;
    logic [15:0] v;
    eff  = (cnt > DEPTH) ? DEPTH : cnt;
    half = (code == 7) ? 64 : (1 << code);
    for (int k = 0; k < DEPTH; k++) begin
      txMem[k] = 8'($urandom);
      wr(8 + k, txMem[k]);
    end
    respSeed = 8'($urandom);
    slvCpha  = pha[0];
    for (int k = 0; k < 16; k++) slvRx[k] = 8'h00;
    wr(0, code | (pol << 4) | (pha << 5));
    wr(1, (typ << 8) | cnt);
    wr(4, mask);
    wr(3, 1);
    falls0 = csFalls;
    wr(2, (prep << 8) | (dev << 4) | 1);
    waitIdle();
    check(csFalls == falls0 + 1, "R7 select pulses", csFalls - falls0, 1);
    check(lastSel == ~(4'd1 << dev), "R7 select line", lastSel, ~(4'd1 << dev) & 4'hF);
    check(eCnt == 16 * eff, "R4 clock edges (R10 clamp)", eCnt, 16 * eff);
    check((t2 - t1) == time'(4 * half), "R2 half period", t2 - t1, 4 * half);
    check(sclk == pol[0], "R3 idle clock level", sclk, pol);
    tail = 0;
    for (int k = 0; k < eff; k++) begin
      logic [7:0] e;
      e = expWr(typ, k, prep) ? txMem[k] : 8'h00;
      check(slvRx[k] == e, "R4 R5 mosi byte", slvRx[k], e);
      if (expRd(typ, k, prep)) tail++;
    end
    rd(6, v);
    check(int'(v) == tail, "R6 receive tail", v, tail);
    j = 0;
    for (int k = 0; k < eff; k++) begin
      if (expRd(typ, k, prep)) begin
        rd(8 + j, v);
        check(v[7:0] == respByte(respSeed, k), "R3 R6 captured byte", v[7:0], respByte(respSeed, k));
        j++;
      end
    end
    rd(3, v);
    check(v[0] == 1'b1, "R9 done flag", v[0], 1);
    check(irq == mask[0], "R9 irq gated by mask", irq, mask);
    wr(3, 1);
    #1 check(irq == 1'b0, "R9 clear drops irq", irq, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] v;
    int falls0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(csN == 4'hF, "R1 selects idle", csN, 4'hF);
    check(sclk == 1'b0, "R1 sclk low", sclk, 0);
    check(irq == 1'b0, "R1 irq low", irq, 0);
    rstN = 1'b1;
    rd(3, v); check(v == 0, "R1 done clear", v, 0);
    rd(5, v); check(v == 0, "R1 not busy", v, 0);
    rd(6, v); check(v == 0, "R1 tail zero", v, 0);

    // directed message kinds and modes
    runMsg(0, 4, 0, 0, 0, 0, 0, 1);
    runMsg(1, 3, 0, 3, 1, 1, 1, 1);
    runMsg(2, 5, 2, 1, 2, 0, 1, 1);   // R5 prepend
    runMsg(2, 8, 0, 2, 0, 1, 0, 1);
    runMsg(3, 2, 0, 0, 1, 1, 1, 1);
    runMsg(0, 1, 0, 2, 7, 0, 0, 1);   // R2 code 7
    runMsg(0, 12, 0, 1, 0, 0, 1, 1);  // R10 clamp
    runMsg(2, 3, 9, 3, 0, 1, 1, 1);   // R5 prepend beyond count
    runMsg(1, 2, 0, 0, 0, 0, 0, 0);   // R9 masked

    // random messages
    for (int n = 0; n < 12; n++) begin
      runMsg(int'($urandom % 4), 1 + int'($urandom % 8), int'($urandom % 4),
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 2),
             int'($urandom % 2), 1);
    end

    // R10: zero-length message
    wr(3, 1);
    wr(1, 0);
    falls0 = csFalls;
    wr(2, 1);
    rd(5, v); check(v[0] == 1'b0, "R10 zero count not busy", v, 0);
    rd(3, v); check(v[0] == 1'b1, "R10 zero count done", v, 1);
    check(csFalls == falls0, "R10 zero count no select", csFalls - falls0, 0);

    // R7: device id out of range
    wr(3, 1);
    wr(1, 2);
    wr(2, (5 << 4) | 1);
    rd(5, v); check(v[0] == 1'b0, "R7 bad id not busy", v, 0);
    rd(3, v); check(v[0] == 1'b0, "R7 bad id no done", v, 0);
    check(csFalls == falls0, "R7 bad id no select", csFalls - falls0, 0);

    // R8: command while busy is ignored
    wr(0, 3);
    wr(1, 4);
    slvCpha = 1'b0;
    falls0 = csFalls;
    wr(2, 1);
    repeat (10) @(negedge clk);
    rd(5, v); check(v[0] == 1'b1, "R8 busy during message", v, 1);
    wr(2, (2 << 4) | 1);
    waitIdle();
    check(csFalls == falls0 + 1, "R8 second command ignored", csFalls - falls0, 1);
    check(lastSel == 4'b1110, "R8 device kept", lastSel, 4'b1110);
    check(eCnt == 64, "R8 length kept", eCnt, 64);

    finish();
  end

endmodule